// File: doc/BRIEF.md
# Masked Packed-Lane Result Writer

This block sits around a per-lane function unit that works on a 512-bit vector split into eight 64-bit lanes. On the way in, it builds the source vector that the lane function sees. Each lane normally takes its own 64 bits. When a broadcast is requested and the operand came from memory, the low 64-bit element is copied to every lane instead. On the way out, it takes the per-lane results and the per-lane exception bits from the lane function and writes a new destination vector under an 8-bit write mask.

A separate no-mask input marks every lane as active. A lane that is not active either keeps its old destination value (merging) or is cleared to zero (zeroing). The exception output is the OR of the exception bits of the active lanes only. The destination and the exception summary are registered. They load on the clock edge where the input-valid strobe is high and hold their value otherwise. The block does no arithmetic. The lane function is supplied from outside.

Top module: `masked_lane_writer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0, `dst_out` is all zeros and `exc_out` is 0.
- R2: Lane j is the bit range j*64+63 down to j*64. When `wmask[j]` is 1, lane j of `dst_out` takes lane j of `lane_res`.
- R3: When `nomask` is 1, every lane takes its `lane_res` value, whatever the value of `wmask`.
- R4: When `zero_mode` is 0, a lane whose mask bit is 0 (and `nomask` is 0) takes lane j of `prev_dst`.
- R5: When `zero_mode` is 1, a lane whose mask bit is 0 (and `nomask` is 0) is written with 0.
- R6: When `bcast_en` and `src_mem` are both 1, every 64-bit lane of `lane_src` equals `src_vec[63:0]`.
- R7: When `bcast_en` is 1 and `src_mem` is 0, the broadcast request is ignored and `lane_src` equals `src_vec`. The same holds whenever `bcast_en` is 0.
- R8: `dst_out` and `exc_out` are updated exactly one cycle after a cycle with `in_valid` high, and `out_valid` is high in that cycle only. After a cycle with `in_valid` low, `dst_out` and `exc_out` keep their values and `out_valid` is 0. Strobes in consecutive cycles each produce a result.
- R9: `exc_out` is the OR of `lane_exc[j]` over the active lanes only. Inactive lanes never contribute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe; loads the result registers |
| src_vec | input | 512 | Raw source operand |
| bcast_en | input | 1 | Broadcast request |
| src_mem | input | 1 | Source operand came from memory |
| lane_src | output | 512 | Per-lane source sent to the lane function |
| lane_res | input | 512 | Per-lane results from the lane function |
| lane_exc | input | 8 | Per-lane exception bits from the lane function |
| prev_dst | input | 512 | Previous destination value |
| wmask | input | 8 | Write mask, one bit per lane |
| nomask | input | 1 | Treat every lane as active |
| zero_mode | input | 1 | 1 = zeroing, 0 = merging for inactive lanes |
| out_valid | output | 1 | New destination present this cycle |
| dst_out | output | 512 | Registered destination vector |
| exc_out | output | 1 | Registered OR of exceptions over active lanes |

## Verification
Source broadcast and masked write-back can take effect in the same operation. The broadcast shapes what every lane computes, and the mask then chooses which of those values reach the destination. The bench provokes this with broadcast vectors whose low element has its sign bit set, so the stub lane function raises an exception in every lane. These vectors run under both zeroing and merging with sparse masks. A result is correct only when the replicated value appears in the active lanes alone and the exception bit reflects only those lanes.

// File: rtl/mlw_pkg.sv
package mlw_pkg;

    localparam int unsigned LANES  = 8;
    localparam int unsigned LANE_W = 64;
    localparam int unsigned VEC_W  = LANES * LANE_W;

    typedef struct packed {
        logic             nomask;
        logic             zero_mode;
        logic [LANES-1:0] wmask;
    } mask_ctrl_t;

    typedef enum logic [1:0] {
        LANE_WRITE = 2'd0,
        LANE_KEEP  = 2'd1,
        LANE_CLEAR = 2'd2
    } lane_act_e;

    function automatic logic [LANES-1:0] active_lanes(input mask_ctrl_t c);
        return c.nomask ? {LANES{1'b1}} : c.wmask;
    endfunction

    function automatic lane_act_e lane_action(input logic active, input logic zero_mode);
        if (active)    return LANE_WRITE;
        if (zero_mode) return LANE_CLEAR;
        return LANE_KEEP;
    endfunction

endpackage

// File: rtl/mlw_src_fanout.sv
module mlw_src_fanout #(
    parameter int unsigned LANES  = mlw_pkg::LANES,
    parameter int unsigned LANE_W = mlw_pkg::LANE_W,
    localparam int unsigned VW    = LANES * LANE_W
) (
    input  logic [VW-1:0] src_vec,
    input  logic          bcast_en,
    input  logic          src_mem,
    output logic [VW-1:0] lane_src
);
    logic replicate;
    assign replicate = bcast_en & src_mem;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_src[j*LANE_W +: LANE_W] =
            replicate ? src_vec[LANE_W-1:0] : src_vec[j*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/mlw_lane_merge.sv
module mlw_lane_merge
    import mlw_pkg::*;
#(
    parameter int unsigned LANES  = mlw_pkg::LANES,
    parameter int unsigned LANE_W = mlw_pkg::LANE_W,
    localparam int unsigned VW    = LANES * LANE_W
) (
    input  logic [LANES-1:0] active,
    input  logic             zero_mode,
    input  logic [VW-1:0]    lane_res,
    input  logic [VW-1:0]    prev_dst,
    output logic [VW-1:0]    dst_next
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        lane_act_e act;
        assign act = lane_action(active[j], zero_mode);
        always_comb begin
            unique case (act)
                LANE_WRITE: dst_next[j*LANE_W +: LANE_W] = lane_res[j*LANE_W +: LANE_W];
                LANE_KEEP:  dst_next[j*LANE_W +: LANE_W] = prev_dst[j*LANE_W +: LANE_W];
                default:    dst_next[j*LANE_W +: LANE_W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/mlw_exc_reduce.sv
module mlw_exc_reduce #(
    parameter int unsigned LANES = mlw_pkg::LANES
) (
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] lane_exc,
    output logic             exc_any
);
    assign exc_any = |(active & lane_exc);
endmodule

// File: rtl/masked_lane_writer.sv
module masked_lane_writer
    import mlw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_vec,
    input  logic             bcast_en,
    input  logic             src_mem,
    output logic [VEC_W-1:0] lane_src,
    input  logic [VEC_W-1:0] lane_res,
    input  logic [LANES-1:0] lane_exc,
    input  logic [VEC_W-1:0] prev_dst,
    input  logic [LANES-1:0] wmask,
    input  logic             nomask,
    input  logic             zero_mode,
    output logic             out_valid,
    output logic [VEC_W-1:0] dst_out,
    output logic             exc_out
);
    mask_ctrl_t       ctrl;
    logic [LANES-1:0] active;
    logic [VEC_W-1:0] dst_next;
    logic             exc_next;

    assign ctrl   = '{nomask: nomask, zero_mode: zero_mode, wmask: wmask};
    assign active = active_lanes(ctrl);

    mlw_src_fanout #(.LANES(LANES), .LANE_W(LANE_W)) u_fanout (
        .src_vec  (src_vec),
        .bcast_en (bcast_en),
        .src_mem  (src_mem),
        .lane_src (lane_src)
    );

    mlw_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .active    (active),
        .zero_mode (ctrl.zero_mode),
        .lane_res  (lane_res),
        .prev_dst  (prev_dst),
        .dst_next  (dst_next)
    );

    mlw_exc_reduce #(.LANES(LANES)) u_exc (
        .active   (active),
        .lane_exc (lane_exc),
        .exc_any  (exc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst_out   <= '0;
            exc_out   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_out <= dst_next;
                exc_out <= exc_next;
            end
        end
    end
endmodule

// File: rtl/mlw_checker.sv
module mlw_checker
    import mlw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [VEC_W-1:0] src_vec,
    input logic             bcast_en,
    input logic             src_mem,
    input logic [VEC_W-1:0] lane_src,
    input logic [VEC_W-1:0] lane_res,
    input logic [LANES-1:0] lane_exc,
    input logic [LANES-1:0] wmask,
    input logic             nomask,
    input logic             zero_mode,
    input logic             out_valid,
    input logic [VEC_W-1:0] dst_out,
    input logic             exc_out
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && dst_out == '0 && !exc_out));

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(dst_out) && $stable(exc_out)));

    a_r3_nomask_all: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nomask) |=> (dst_out == $past(lane_res)));

    a_r5_zero_empty: assert property (@(posedge clk) disable iff (rst)
        (in_valid && zero_mode && !nomask && wmask == '0) |=> (dst_out == '0 && !exc_out));

    a_r9_no_active_exc: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !nomask && (wmask & lane_exc) == '0) |=> !exc_out);

    a_r7_no_replicate: assert property (@(posedge clk) disable iff (rst)
        !(bcast_en && src_mem) |-> (lane_src == src_vec));

    for (genvar j = 1; j < LANES; j++) begin : g_bc
        a_r6_bcast_lane: assert property (@(posedge clk) disable iff (rst)
            (bcast_en && src_mem) |-> (lane_src[j*LANE_W +: LANE_W] == lane_src[LANE_W-1:0]));
    end
endmodule

bind masked_lane_writer mlw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_vec   (src_vec),
    .bcast_en  (bcast_en),
    .src_mem   (src_mem),
    .lane_src  (lane_src),
    .lane_res  (lane_res),
    .lane_exc  (lane_exc),
    .wmask     (wmask),
    .nomask    (nomask),
    .zero_mode (zero_mode),
    .out_valid (out_valid),
    .dst_out   (dst_out),
    .exc_out   (exc_out)
);

// File: tb/tb_masked_lane_writer.sv
`timescale 1ns/1ps
module tb_masked_lane_writer;
    import mlw_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [VEC_W-1:0] src_vec;
    logic             bcast_en;
    logic             src_mem;
    logic [VEC_W-1:0] lane_src;
    logic [VEC_W-1:0] lane_res;
    logic [LANES-1:0] lane_exc;
    logic [VEC_W-1:0] prev_dst;
    logic [LANES-1:0] wmask;
    logic             nomask;
    logic             zero_mode;
    logic             out_valid;
    logic [VEC_W-1:0] dst_out;
    logic             exc_out;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [VEC_W-1:0] dst;
        logic             exc;
        string            req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    masked_lane_writer dut (.*);

    // Stub lane function: swap halves and xor a constant; exception = sign bit.
    function automatic logic [63:0] stub_f(input logic [63:0] x);
        return {x[31:0], x[63:32]} ^ 64'h0F0F_1234_F0F0_5678;
    endfunction

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            lane_res[j*64 +: 64] = stub_f(lane_src[j*64 +: 64]);
            lane_exc[j]          = lane_src[j*64 + 63];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: applies one operation and queues its expected result.
    task automatic apply(input logic [VEC_W-1:0] s, input logic bc, input logic mem,
                         input logic [LANES-1:0] m, input logic nm, input logic zm,
                         input logic [VEC_W-1:0] prev, input string req);
        logic [VEC_W-1:0] esrc;
        exp_t e;
        e.dst = '0;
        e.exc = 1'b0;
        e.req = req;
        for (int j = 0; j < LANES; j++) begin
            logic [63:0] sl;
            logic        act;
            sl  = (bc && mem) ? s[63:0] : s[j*64 +: 64];
            act = nm | m[j];
            esrc[j*64 +: 64] = sl;
            if (act) e.dst[j*64 +: 64] = stub_f(sl);
            else     e.dst[j*64 +: 64] = zm ? 64'd0 : prev[j*64 +: 64];
            if (act && sl[63]) e.exc = 1'b1;
        end
        src_vec = s; bcast_en = bc; src_mem = mem; wmask = m;
        nomask = nm; zero_mode = zm; prev_dst = prev; in_valid = 1'b1;
        #1;
        check(lane_src == esrc, (bc && mem) ? "R6" : "R7", "lane_src", lane_src, esrc);
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected out_valid", {511'd0, out_valid}, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(dst_out == e.dst, e.req, "dst_out", dst_out, e.dst);
                check(exc_out == e.exc, "R9", "exc_out", {511'd0, exc_out}, {511'd0, e.exc});
            end
        end
    end

    function automatic logic [VEC_W-1:0] pat(input logic [63:0] seed);
        logic [VEC_W-1:0] v;
        for (int j = 0; j < LANES; j++)
            v[j*64 +: 64] = seed ^ (64'h1111_0000_0101_0011 * (j + 1)) ^ (64'(j) << 60);
        return v;
    endfunction

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [VEC_W-1:0] held;
        logic [VEC_W-1:0] prv;
        prv = pat(64'hDEAD_BEEF_CAFE_0001);
        rst = 1'b1; in_valid = 1'b0; src_vec = '0; bcast_en = 1'b0; src_mem = 1'b0;
        prev_dst = '0; wmask = '0; nomask = 1'b0; zero_mode = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_valid && dst_out == '0 && !exc_out, "R1", "reset state",
              dst_out, '0);
        rst = 1'b0;
        @(negedge clk);

        apply(pat(64'h0123_4567_89AB_CDEF), 0, 0, 8'h00, 1, 0, prv, "R3");   // nomask override
        idle(1);
        apply(pat(64'h8000_0000_0000_0042), 0, 0, 8'hA5, 0, 0, prv, "R2/R4"); // merge
        idle(1);
        apply(pat(64'h7000_0000_0000_0099), 0, 0, 8'h3C, 0, 1, prv, "R2/R5"); // zero
        idle(1);
        apply(pat(64'hF000_0000_0000_0007), 0, 0, 8'h00, 0, 1, prv, "R5");    // nothing active
        idle(1);
        apply(pat(64'h5555_AAAA_0000_1111), 0, 0, 8'h00, 1, 1, prv, "R3");    // override in zero mode
        idle(1);
        // broadcast + masking in the same operation
        apply({448'd0, 64'h8123_4567_0000_ABCD}, 1, 1, 8'h81, 0, 1, prv, "R6/R5");
        apply({448'd0, 64'h8123_4567_0000_ABCD} | pat(64'h3), 1, 1, 8'h42, 0, 0, prv, "R6/R4");
        idle(1);
        apply(pat(64'h8642_0000_1357_0000), 1, 0, 8'hFF, 0, 0, prv, "R7");   // register source
        apply(pat(64'h0000_2468_0000_9BDF), 0, 1, 8'h0F, 0, 0, prv, "R7");   // no broadcast bit
        // back-to-back then hold
        apply(pat(64'hFEDC_BA98_7654_3210), 0, 0, 8'h18, 0, 1, prv, "R8");
        idle(1);
        held = dst_out;
        idle(3);
        check(!out_valid, "R8", "out_valid while idle", {511'd0, out_valid}, '0);
        check(dst_out == held, "R8", "dst_out hold", dst_out, held);
        idle(2);
        check(exp_q.size() == 0, "R8", "results missing", VEC_W'(exp_q.size()), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule